// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a free-running supervision counter that begins counting as soon as the system reset input is released, with no enable needed. It advances once per pulse of a slow 256 Hz tick strobe, which comes from a low-speed clock outside the block. If software does not service it within the selected period, it escalates in two steps. The first expiry sends a one-cycle non-maskable interrupt request, so firmware gets a chance to recover. A second expiry, with still no service, raises a reset request. That request stays high until the system reset input is applied.

Software reaches the block through one byte-wide write port that selects between two registers. The service register restarts the count only after a two-byte unlock: first 5Ah, then A5h. A phase state machine with the states `PH_IDLE` and `PH_ARMED` tracks which key byte is expected next. The configuration register holds the period select and a stop-enable bit. When both that bit and the `deep_halt` input are high, the count is frozen.

The escalation state machine has three states:
- `ESC_COUNT`: normal counting. An overflow pulses the interrupt and moves to `ESC_WARNED`.
- `ESC_WARNED`: a key clear returns to `ESC_COUNT`. A second overflow moves to `ESC_RESET`.
- `ESC_RESET`: holds the reset request and leaves only on `rst_n`.

Top module: `wdt_two_stage`

## Requirements
- R1: After `rst_n` is released, counting starts with no software action. While in reset, and until the first expiry, `wdt_nmi` and `wdt_rst_req` are both low.
- R2: Bits [1:0] of the configuration register (`wr_sel`=1) select the period. Value m gives a period of 32·4^m ticks: 32, 128, 512 or 2048. `rst_n` returns this register to 0, which is a period of 32.
- R3: The first expiry makes `wdt_nmi` high for exactly one cycle, the cycle after the clock edge that samples the period-th tick.
- R4: A second expiry with no clear in between makes `wdt_rst_req` high, with no further `wdt_nmi` pulse. The request stays high, whatever the ticks and writes, until `rst_n` is applied.
- R5: On the service register (`wr_sel`=0), a write of 5Ah in `PH_IDLE` moves to `PH_ARMED`. A following A5h write in `PH_ARMED` clears the count, cancels a pending warning, and returns to `PH_IDLE`.
- R6: Other writes leave the count and the phase unchanged:
  - A5h written in `PH_IDLE`.
  - 5Ah written in `PH_ARMED`.
  - Any other byte written to the service register.
  - Any write to the configuration register. Such a write is never taken as a key.
- R7: A new period value takes effect only at the next key clear. The count in progress keeps its old period.
- R8: When configuration bit 2 is 1 and `deep_halt` is high, ticks are ignored. When bit 2 is 0, `deep_halt` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset. Returns all state to defaults |
| tick | input | 1 | One-cycle 256 Hz count strobe |
| deep_halt | input | 1 | High while the chip is in its deepest low-power mode |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 = service register, 1 = configuration register |
| wr_data | input | 8 | Write data |
| wdt_nmi | output | 1 | One-cycle non-maskable interrupt request |
| wdt_rst_req | output | 1 | Sticky system reset request |

## Verification
A wrong phase state only shows up later, at the next A5h write. That write either fails to clear, and the interrupt then arrives early by the ticks already counted, or it clears when it should not, and the interrupt arrives late. A wrong latched period or escalation state shows up at the next expiry, at most 2048 ticks away, as an interrupt or reset edge on the wrong tick. So the bench sweeps every period value and every key ordering. For each one it measures the exact tick index of each output edge against a count it computes itself.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ESC_COUNT  = 2'd0,
        ESC_WARNED = 2'd1,
        ESC_RESET  = 2'd2
    } esc_state_t;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_ARMED = 1'b1
    } key_phase_t;

    localparam logic [7:0] KEY_ARM  = 8'h5A;
    localparam logic [7:0] KEY_FIRE = 8'hA5;
    localparam logic       SEL_SERVICE = 1'b0;
    localparam logic       SEL_CONFIG  = 1'b1;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              clear_o,
    output logic [SEL_W-1:0]  period_sel_o,
    output logic              halt_stop_en_o
);
    localparam int CFG_W = SEL_W + 1;

    key_phase_t       phase_q, phase_d;
    logic [CFG_W-1:0] cfg_q;
    logic             svc_wr, cfg_wr;

    assign svc_wr = wr_en && (wr_sel == SEL_SERVICE);
    assign cfg_wr = wr_en && (wr_sel == SEL_CONFIG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    always_comb begin
        phase_d = phase_q;
        clear_o = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (svc_wr && wr_data == KEY_ARM) phase_d = PH_ARMED;
            end
            PH_ARMED: begin
                if (svc_wr && wr_data == KEY_FIRE) begin
                    phase_d = PH_IDLE;
                    clear_o = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= wr_data[CFG_W-1:0];
    end

    assign period_sel_o   = cfg_q[SEL_W-1:0];
    assign halt_stop_en_o = cfg_q[SEL_W];

    // R5: a clear always leaves the sequencer idle
    p_clear_idles_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |=> (phase_q == PH_IDLE));
    // R6: arming only follows a 5Ah service write
    p_arm_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ARMED && $past(phase_q) == PH_IDLE) |->
        $past(wr_en && wr_sel == SEL_SERVICE && wr_data == KEY_ARM));
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int BASE_LOG2 = 5,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             stop,
    input  logic             clear,
    input  logic [SEL_W-1:0] period_sel,
    output logic             overflow_o
);
    localparam int NUM_MODES = 1 << SEL_W;
    localparam int CNT_W     = BASE_LOG2 + 2 * (NUM_MODES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] last_val;
    logic             advance;

    function automatic logic [CNT_W-1:0] last_of(input logic [SEL_W-1:0] s);
        logic [CNT_W:0] span;
        span = ({{CNT_W{1'b0}}, 1'b1} << (BASE_LOG2 + 2 * int'(s))) - 1'b1;
        return span[CNT_W-1:0];
    endfunction

    assign last_val   = last_of(sel_q);
    assign advance    = tick && !stop;
    assign overflow_o = advance && !clear && (cnt_q == last_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sel_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
            sel_q <= period_sel;
        end else if (advance) begin
            cnt_q <= (cnt_q == last_val) ? '0 : cnt_q + 1'b1;
        end
    end

    // R2: the count never passes the end of the latched period
    p_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_val);
    // R8: a stopped counter without clear holds its value
    p_stop_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !clear) |=> $stable(cnt_q));
    // R7: the period in force changes only at a clear
    p_period_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> $stable(sel_q));
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic overflow,
    input  logic clear,
    output logic nmi_o,
    output logic rst_req_o
);
    esc_state_t state_q, state_d;
    logic       nmi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ESC_COUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ESC_COUNT:  if (overflow) state_d = ESC_WARNED;
            ESC_WARNED: begin
                if (clear)         state_d = ESC_COUNT;
                else if (overflow) state_d = ESC_RESET;
            end
            ESC_RESET:  state_d = ESC_RESET;
            default:    state_d = ESC_COUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nmi_q <= 1'b0;
        else        nmi_q <= (state_q == ESC_COUNT) && overflow;
    end

    assign nmi_o     = nmi_q;
    assign rst_req_o = (state_q == ESC_RESET);

    // R3: the interrupt is one cycle wide
    p_nmi_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |=> !nmi_o);
    // R4: the reset request holds until system reset
    p_rst_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> rst_req_o);
    // R4: no interrupt once reset is requested
    p_no_nmi_in_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> !nmi_o);
    // R3: an interrupt follows an overflow seen while counting
    p_nmi_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_o) |-> $past(overflow));
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
    parameter int BASE_LOG2 = 5,
    parameter int SEL_W     = 2,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              deep_halt,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wdt_nmi,
    output logic              wdt_rst_req
);
    logic             key_clear;
    logic [SEL_W-1:0] period_sel;
    logic             halt_stop_en;
    logic             overflow;
    logic             stop;

    assign stop = halt_stop_en && deep_halt;

    wdt_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_sel         (wr_sel),
        .wr_data        (wr_data),
        .clear_o        (key_clear),
        .period_sel_o   (period_sel),
        .halt_stop_en_o (halt_stop_en)
    );

    wdt_tick_counter #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .stop       (stop),
        .clear      (key_clear),
        .period_sel (period_sel),
        .overflow_o (overflow)
    );

    wdt_escalate u_esc (
        .clk       (clk),
        .rst_n     (rst_n),
        .overflow  (overflow),
        .clear     (key_clear),
        .nmi_o     (wdt_nmi),
        .rst_req_o (wdt_rst_req)
    );
endmodule

// File: tb/tb_wdt_two_stage.sv
module tb_wdt_two_stage;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       deep_halt = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wdt_nmi, wdt_rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wdt_two_stage dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .deep_halt(deep_halt),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .wdt_nmi(wdt_nmi), .wdt_rst_req(wdt_rst_req)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; deep_halt = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic key_clear();
        wr(1'b0, 8'h5A);
        wr(1'b0, 8'hA5);
    endtask

    // applies n back-to-back ticks; indices count ticks applied before sampling
    task automatic run(input int n, output int nmi_at, output int rst_at, output int nmi_cnt);
        nmi_at = -1; rst_at = -1; nmi_cnt = 0;
        for (int k = 0; k <= n; k++) begin
            @(negedge clk);
            if (wdt_nmi) begin
                nmi_cnt++;
                if (nmi_at < 0) nmi_at = k;
            end
            if (wdt_rst_req && rst_at < 0) rst_at = k;
            tick = (k < n);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int na, ra, nc, p;
        repeat (2) @(negedge clk);
        check("R1", "nmi in reset", int'(wdt_nmi), 0);
        check("R1", "rst_req in reset", int'(wdt_rst_req), 0);
        rst_n = 1'b1;

        // R1/R3/R4 default period without any software action
        run(70, na, ra, nc);
        check("R1", "default first expiry tick", na, 32);
        check("R3", "nmi pulse count", nc, 1);
        check("R4", "reset request tick", ra, 64);
        key_clear();
        run(10, na, ra, nc);
        check("R4", "rst_req held after writes and ticks", int'(wdt_rst_req), 1);
        check("R4", "no nmi while reset requested", nc, 0);

        // R2 sweep over all period selections
        for (int m = 0; m < 4; m++) begin
            p = 32 << (2 * m);
            do_reset();
            wr(1'b1, 8'(m));
            key_clear();
            run(2 * p + 2, na, ra, nc);
            check("R2", $sformatf("mode %0d nmi tick", m), na, p);
            check("R2", $sformatf("mode %0d rst tick", m), ra, 2 * p);
            check("R3", $sformatf("mode %0d nmi count", m), nc, 1);
        end

        // R2 reset restores period 0
        do_reset();
        wr(1'b1, 8'd1);
        key_clear();
        do_reset();
        key_clear();
        run(40, na, ra, nc);
        check("R2", "period after reset", na, 32);

        // R7 period change waits for a clear
        do_reset();
        run(10, na, ra, nc);
        wr(1'b1, 8'd2);
        run(30, na, ra, nc);
        check("R7", "old period kept", na, 22);
        key_clear();
        run(520, na, ra, nc);
        check("R7", "new period after clear", na, 512);

        // R5 valid sequence restarts count and cancels warning
        do_reset();
        run(20, na, ra, nc);
        key_clear();
        run(40, na, ra, nc);
        check("R5", "restart after key pair", na, 32);
        key_clear();
        run(63, na, ra, nc);
        check("R5", "warning cancelled: no reset", ra, -1);
        check("R5", "warning cancelled: nmi again", na, 32);

        // R6 lone A5h in idle phase ignored
        do_reset();
        run(20, na, ra, nc);
        wr(1'b0, 8'hA5);
        run(20, na, ra, nc);
        check("R6", "lone A5h ignored", na, 12);

        // R6 repeated 5Ah and stray byte keep armed phase
        do_reset();
        run(5, na, ra, nc);
        wr(1'b0, 8'h5A);
        wr(1'b0, 8'h5A);
        wr(1'b0, 8'h33);
        wr(1'b0, 8'hA5);
        run(40, na, ra, nc);
        check("R6", "arm survives repeats and stray byte", na, 32);

        // R6 config-register 5Ah is not a key; new mode not applied
        do_reset();
        run(5, na, ra, nc);
        wr(1'b1, 8'h5A);
        wr(1'b0, 8'hA5);
        run(30, na, ra, nc);
        check("R6", "config write not a key", na, 27);

        // R6 A5h right after a clear ignored
        do_reset();
        key_clear();
        run(10, na, ra, nc);
        wr(1'b0, 8'hA5);
        run(30, na, ra, nc);
        check("R6", "A5h after clear ignored", na, 22);

        // R8 stop in deep halt
        do_reset();
        wr(1'b1, 8'h04);
        key_clear();
        deep_halt = 1'b1;
        run(50, na, ra, nc);
        check("R8", "halted: no expiry", na, -1);
        deep_halt = 1'b0;
        run(40, na, ra, nc);
        check("R8", "resumes full period", na, 32);
        do_reset();
        wr(1'b1, 8'h00);
        key_clear();
        deep_halt = 1'b1;
        run(40, na, ra, nc);
        check("R8", "halt ignored when not enabled", na, 32);
        deep_halt = 1'b0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule